// File: doc/BRIEF.md
# Serial ADC Read Controller

This block sits in the system clock domain and drives a three-wire serial analog-to-digital converter: an active-low select line, a data clock that it generates by dividing the system clock, and a serial data line returned by the converter. A single-cycle `start` pulse begins one read. The controller pulls select low and waits a setup interval. It then toggles the data clock and samples the data line on each rising edge. The first few rising edges carry no data and are thrown away. The next twelve edges bring the conversion result most-significant bit first.

Once the last needed bit has been sampled, the controller finishes the high half of that clock period. It then drops the clock and returns select high in the same cycle, so the converter can power down quickly. The assembled word appears on `result`, together with a one-cycle `valid` strobe. An optional verify mode keeps the clock running for eleven more edges. On those edges the converter replays the word starting from B1 and ending at B11. Each replayed bit is compared against the captured word, and any difference raises `mismatch`.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, `cs_n` is 1 and `sclk`, `busy` and `valid` are 0.
- R2: A `start` pulse while idle drives `cs_n` low and `busy` high on the next clock edge. Select then stays low for exactly SETUP_CYC + HALF_DIV system cycles before the first rising edge of `sclk`, and never for fewer than SETUP_CYC cycles.
- R3: `sclk` is high only while `cs_n` is low. Each high phase and each low phase lasts HALF_DIV system cycles.
- R4: The first LEAD_SLOTS (3) rising edges of `sclk` are discarded. The next 12 rising edges deliver B11 down to B0, and `result` bit 11 holds the first of these bits.
- R5: A normal read (`verify_en` = 0 at start) produces exactly 15 rising edges of `sclk`. `cs_n` returns high at the falling edge that follows the 15th rising edge.
- R6: `valid` is a one-cycle pulse, asserted in the cycle in which `cs_n` returns high and `busy` clears. `result` and `mismatch` change only in that cycle and hold their values until the next pulse.
- R7: A verify read (`verify_en` = 1 at start) produces exactly 26 rising edges. Edges 16 to 26 are expected to carry B1 up to B11. `mismatch` is 1 if any of these edges differs from the captured word, and 0 otherwise. In a normal read `mismatch` is always 0.
- R8: A `start` pulse while `busy` is high is ignored. The running read keeps its edge count and mode, and no second read follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one read (acted on only while idle) |
| verify_en | input | 1 | Selects verify mode for the read being started |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Generated data clock |
| busy | output | 1 | A read is in progress |
| result | output | 12 | Last assembled conversion word |
| valid | output | 1 | One-cycle strobe marking a new result |
| mismatch | output | 1 | Replay comparison failed on the last verify read |

## Verification
The assertions check on every cycle several properties that hold at all times:
- the data clock is never high while select is high;
- the setup interval before the first rising edge is always met;
- `valid` is a single-cycle pulse, and it appears only while select is high and the block is idle;
- `result` holds between pulses;
- a start request during the data phase never restarts the sequence.

Some behaviour depends on the order of bits on the wire, so only the bench scenarios can show it. This covers:
- that the three leading edges are discarded;
- that bits are packed MSB-first;
- the exact edge counts of 15 and 26;
- that a corrupted replay bit raises `mismatch` in verify mode but not in a normal read.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_SHIFT = 2'd2
   } rd_state_e;
endpackage

// File: rtl/adc_rd_clkgen.sv
// Divided data clock: each phase lasts HALF_DIV system cycles while run is high.
module adc_rd_clkgen #(
   parameter int HALF_DIV = 320
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise,
   output logic fall
);
   localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
   localparam logic [CW-1:0] PH_LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] ph_cnt;
   logic          ph_end;

   if (HALF_DIV < 1) begin : g_bad_div
      $error("adc_rd_clkgen: HALF_DIV must be at least 1");
   end

   assign ph_end = run && (ph_cnt == PH_LAST);
   assign rise   = ph_end && !sclk;
   assign fall   = ph_end && sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_cnt <= '0;
         sclk   <= 1'b0;
      end else if (!run) begin
         ph_cnt <= '0;
         sclk   <= 1'b0;
      end else if (ph_end) begin
         ph_cnt <= '0;
         sclk   <= ~sclk;
      end else begin
         ph_cnt <= ph_cnt + 1'b1;
      end
   end

   // R3: a phase never outlasts HALF_DIV cycles
   assert_phase_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (ph_cnt <= PH_LAST));
endmodule

// File: rtl/adc_rd_assembler.sv
// Packs data slots MSB-first and optionally checks the LSB-first replay.
module adc_rd_assembler #(
   parameter int DATA_W         = 12,
   parameter int LEAD_SLOTS     = 3,
   parameter int VERIFY_SUPPORT = 1,
   parameter int SW             = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample,
   input  logic [SW-1:0]     slot,
   input  logic              din,
   input  logic              verify,
   output logic [DATA_W-1:0] word,
   output logic              err
);
   localparam int IW = $clog2(DATA_W);
   localparam logic [SW-1:0] D_FIRST = SW'(LEAD_SLOTS);
   localparam logic [SW-1:0] D_LAST  = SW'(LEAD_SLOTS + DATA_W - 1);
   localparam logic [SW-1:0] R_FIRST = SW'(LEAD_SLOTS + DATA_W);
   localparam logic [SW-1:0] R_LAST  = SW'(LEAD_SLOTS + 2*DATA_W - 2);

   logic in_data;
   assign in_data = (slot >= D_FIRST) && (slot <= D_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                word <= '0;
      else if (clear)            word <= '0;
      else if (sample && in_data) word <= {word[DATA_W-2:0], din};
   end

   if (VERIFY_SUPPORT != 0) begin : g_verify
      logic          in_replay;
      logic [SW-1:0] rel;
      logic [IW-1:0] ref_idx;
      assign in_replay = verify && (slot >= R_FIRST) && (slot <= R_LAST);
      assign rel       = slot - R_FIRST + 1'b1;
      assign ref_idx   = rel[IW-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      err <= 1'b0;
         else if (clear)  err <= 1'b0;
         else if (sample && in_replay && (din != word[ref_idx])) err <= 1'b1;
      end

      // R7: the compare flag never arises outside verify mode
      assert_err_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!verify && !clear && !err) |=> !err);
   end else begin : g_no_verify
      assign err = 1'b0;
   end
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
   parameter int DATA_W          = 12,
   parameter int LEAD_SLOTS      = 3,
   parameter int HALF_DIV        = 320,
   parameter int SETUP_CYC       = 6,
   parameter int SYS_CLK_HZ      = 200_000_000,
   parameter int CLK_PER_SAMPLE  = 16,
   parameter int MAX_SAMPLE_HZ   = 20_000,
   parameter int VERIFY_SUPPORT  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              verify_en,
   input  logic              sdata,
   output logic              cs_n,
   output logic              sclk,
   output logic              busy,
   output logic [DATA_W-1:0] result,
   output logic              valid,
   output logic              mismatch
);
   import adc_rd_pkg::*;

   localparam int NORM_LAST = LEAD_SLOTS + DATA_W - 1;
   localparam int VER_LAST  = LEAD_SLOTS + 2*DATA_W - 2;
   localparam int SW        = $clog2(VER_LAST + 2);
   localparam int STW       = (SETUP_CYC < 2) ? 1 : $clog2(SETUP_CYC);
   localparam int RATE_HZ   = SYS_CLK_HZ / (2 * HALF_DIV * CLK_PER_SAMPLE);

   if (DATA_W < 2) begin : g_bad_w
      $error("adc_serial_reader: DATA_W must be at least 2");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("adc_serial_reader: SETUP_CYC must be at least 1");
   end
   if (RATE_HZ > MAX_SAMPLE_HZ) begin : g_bad_rate
      $error("adc_serial_reader: divider gives a sample rate above the limit");
   end

   rd_state_e          state;
   logic [STW-1:0]     setup_cnt;
   logic [SW-1:0]      slot;
   logic               verify_q;
   logic               last_seen;
   logic               cs_n_q;
   logic               valid_q;
   logic [DATA_W-1:0]  result_q;
   logic               mism_q;
   logic               run, rise, fall, clear;
   logic [DATA_W-1:0]  word;
   logic               err;
   logic [SW-1:0]      end_slot;

   assign run      = (state == ST_SHIFT);
   assign clear    = (state == ST_IDLE) && start;
   assign end_slot = verify_q ? SW'(VER_LAST) : SW'(NORM_LAST);

   adc_rd_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(run),
      .sclk(sclk), .rise(rise), .fall(fall)
   );

   adc_rd_assembler #(
      .DATA_W(DATA_W), .LEAD_SLOTS(LEAD_SLOTS),
      .VERIFY_SUPPORT(VERIFY_SUPPORT), .SW(SW)
   ) u_asm (
      .clk(clk), .rst_n(rst_n), .clear(clear), .sample(rise),
      .slot(slot), .din(sdata), .verify(verify_q),
      .word(word), .err(err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         setup_cnt <= '0;
         slot      <= '0;
         verify_q  <= 1'b0;
         last_seen <= 1'b0;
         cs_n_q    <= 1'b1;
         valid_q   <= 1'b0;
         result_q  <= '0;
         mism_q    <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  cs_n_q    <= 1'b0;
                  verify_q  <= verify_en && (VERIFY_SUPPORT != 0);
                  setup_cnt <= '0;
                  slot      <= '0;
                  last_seen <= 1'b0;
                  state     <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (setup_cnt == STW'(SETUP_CYC - 1)) state <= ST_SHIFT;
               else                                  setup_cnt <= setup_cnt + 1'b1;
            end
            ST_SHIFT: begin
               if (rise) begin
                  slot <= slot + 1'b1;
                  if (slot == end_slot) last_seen <= 1'b1;
               end
               if (fall && last_seen) begin
                  state    <= ST_IDLE;
                  cs_n_q   <= 1'b1;
                  valid_q  <= 1'b1;
                  result_q <= word;
                  mism_q   <= err;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cs_n     = cs_n_q;
   assign busy     = (state != ST_IDLE);
   assign valid    = valid_q;
   assign result   = result_q;
   assign mismatch = mism_q;

   // cycles select has been low, saturating; used only by the setup check
   logic [15:0] cs_low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cs_low_cnt <= '0;
      else if (cs_n_q)          cs_low_cnt <= '0;
      else if (~&cs_low_cnt)    cs_low_cnt <= cs_low_cnt + 1'b1;
   end

   assert_clk_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n);
   assert_setup_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> (cs_low_cnt >= 16'(SETUP_CYC)));
   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   assert_valid_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (cs_n && !busy));
   assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> ($stable(result) && $stable(mismatch)));
   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run && start) |=> (state != ST_SETUP));
   assert_sel_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);
endmodule

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;
   localparam int HALF  = 4;
   localparam int SETUP = 2;
   localparam int LEAD  = 3;

   typedef struct packed {
      logic [11:0] w;
      logic        ver;
      logic        cor;
      logic        exp_m;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{12'hA5C, 1'b0, 1'b0, 1'b0},
      '{12'h000, 1'b0, 1'b0, 1'b0},
      '{12'hFFF, 1'b0, 1'b0, 1'b0},
      '{12'h801, 1'b1, 1'b0, 1'b0},
      '{12'h3C6, 1'b1, 1'b1, 1'b1},
      '{12'h5A3, 1'b0, 1'b1, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic verify_en = 1'b0;
   logic sdata;
   logic cs_n, sclk, busy, valid, mismatch;
   logic [11:0] result;

   always #2.5 clk = ~clk;

   adc_serial_reader #(
      .HALF_DIV(HALF), .SETUP_CYC(SETUP), .SYS_CLK_HZ(2_560_000)
   ) u_adc_serial_reader (
      .clk(clk), .rst_n(rst_n), .start(start), .verify_en(verify_en),
      .sdata(sdata), .cs_n(cs_n), .sclk(sclk), .busy(busy),
      .result(result), .valid(valid), .mismatch(mismatch)
   );

   // converter model: data changes on falling clock edges
   logic [11:0] m_word = '0;
   logic        m_cor = 1'b0;
   int          idx = 0;
   int          rises = 0;

   always @(negedge cs_n) idx = 0;
   always @(negedge sclk) if (!cs_n) idx = idx + 1;
   always @(posedge sclk) rises = rises + 1;

   always_comb begin
      if (idx < LEAD)             sdata = 1'b1;
      else if (idx < LEAD + 12)   sdata = m_word[LEAD + 11 - idx];
      else if (idx <= LEAD + 22)  sdata = m_word[idx - LEAD - 11] ^ (m_cor && idx == 20);
      else                        sdata = 1'b0;
   end

   int n_checks = 0;
   int n_fail   = 0;

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_read(input vec_t v, input bit poke);
      int cnt;
      int guard;
      m_word = v.w;
      m_cor  = v.cor;
      rises  = 0;
      @(negedge clk);
      start = 1'b1; verify_en = v.ver;
      @(negedge clk);
      start = 1'b0; verify_en = 1'b0;
      check("R2 busy after start", busy, 1);
      check("R2 cs_n after start", cs_n, 0);
      cnt = 0;
      while (sclk === 1'b0 && cnt < 1000) begin cnt++; @(negedge clk); end
      check("R2 setup cycles", cnt, SETUP + HALF);
      cnt = 0;
      while (sclk === 1'b1 && cnt < 1000) begin cnt++; @(negedge clk); end
      check("R3 high phase", cnt, HALF);
      if (poke) begin
         start = 1'b1; verify_en = ~v.ver;
         @(negedge clk);
         start = 1'b0; verify_en = 1'b0;
      end
      guard = 0;
      while (valid !== 1'b1 && guard < 2000) begin
         guard++;
         check("R3 clock gated", (sclk && cs_n) ? 1 : 0, 0);
         @(negedge clk);
      end
      check("R6 cs_n at valid", cs_n, 1);
      check("R6 busy at valid", busy, 0);
      check("R4 result", result, v.w);
      check(v.ver ? "R7 mismatch" : "R7 mismatch normal", mismatch, v.exp_m);
      check(v.ver ? "R7 edge count" : "R5 edge count", rises, v.ver ? 26 : 15);
      @(negedge clk);
      check("R6 valid width", valid, 0);
      repeat (20) @(negedge clk);
      check("R8 no second read", cs_n, 1);
      check("R6 result held", result, v.w);
   endtask

   initial begin
      #2_000_000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 cs_n reset", cs_n, 1);
      check("R1 sclk reset", sclk, 0);
      check("R1 busy reset", busy, 0);
      check("R1 valid reset", valid, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 idle after release", {cs_n, sclk, busy, valid}, 4'b1000);

      for (int i = 0; i < NV; i++) do_read(VECS[i], 1'b0);

      // R8: start during a normal read must not switch it to verify mode
      do_read('{12'h6B9, 1'b0, 1'b1, 1'b0}, 1'b1);
      // R8: start during a verify read keeps 26 edges and the compare
      do_read('{12'h1E7, 1'b1, 1'b1, 1'b1}, 1'b1);
      // R7: clean verify read after a failing one clears the flag
      do_read('{12'hC33, 1'b1, 1'b0, 1'b0}, 1'b0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule